// File: doc/BRIEF.md
# UART Bit-Clock Generator with Fractional Prescaler

This block derives the two timing strobes a UART needs from one fixed reference clock (nominally 62.5 MHz). The reference runs through three dividers in series. A fractional prescaler divides by 1.000 to 63.875 in steps of one eighth. A 16-bit integer divisor follows it, and then an oversampling counter whose ratio can be set from 4 to 16. Each output of the divisor is a sample strobe. Each completed oversampling count is a bit strobe. The bit rate is therefore f_ref / (oversample × prescale × divisor). With all three settings at their minimum the rate is 15.625 Mbit/s.

Software writes the three settings one field at a time through a small write port. The writes go into a holding copy. That copy becomes the running configuration only at a bit boundary, so a bit period is never cut short. Reset loads a backward-compatible configuration: prescale 33.875, divisor 1 and ×16 oversampling, which gives about 115 314 bit/s.

Top module: `uart_bitclk_gen`

## Requirements
- R1: `sample_tick` and `bit_tick` are one-cycle strobes. Every `bit_tick` falls in the same cycle as the last `sample_tick` of its bit, and each bit holds exactly oversample sample strobes.
- R2: Reset is synchronous and active high. It keeps both strobes low, clears all counters and restores prescale 33.875, divisor 1 and oversample 16. Counting from the first cycle after reset, the first `sample_tick` comes in cycle 33 and the first `bit_tick` in cycle 542.
- R3: Address 0 writes the prescaler: integer part in `wr_data[8:3]`, eighths in `wr_data[2:0]`. Counting from a restart, the n-th prescaler output comes after n·I + floor(n·F/8) reference cycles. An integer part of 0 is stored as 1.
- R4: Address 1 writes the 16-bit divisor from `wr_data[15:0]`. A value of 0 divides by 65536.
- R5: Address 2 writes the oversample ratio from `wr_data[4:0]`. Values below 4 are stored as 4 and values above 16 as 16.
- R6: A bit lasts oversample × prescale × divisor reference cycles on average. With settings 7, 3.875 and 5 the measured rate is within 0.0065 % of 460 800 bit/s.
- R7: A written setting takes effect only at the first `bit_tick` after the write. The bit already in progress keeps the old timing. At that boundary the counters and the fraction accumulator restart from zero.
- R8: A write that lands in the same cycle as a loading `bit_tick` is held. That boundary loads the settings written before it, and the new value takes effect at the following boundary.
- R9: A write to address 3 has no effect on the timing.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Reference clock |
| rst | input | 1 | Synchronous active-high reset |
| wr_en | input | 1 | Write strobe for one setting |
| wr_addr | input | 2 | Setting select: 0 prescaler, 1 divisor, 2 oversample, 3 none |
| wr_data | input | 16 | Write data |
| sample_tick | output | 1 | Strobe at the oversampled rate |
| bit_tick | output | 1 | Strobe at the bit rate |

## Verification
Two events can fall in the same cycle: a setting write and the bit boundary that loads the held settings. The bench forces this by watching for a visible `bit_tick` and driving a write into that very clock edge, while a previous write is still held. It then checks that the next three bit periods follow the old, the first-written and the second-written settings in turn. The other coincidence is the bit strobe landing on the last sample strobe. It is judged by counting sample strobes per bit over every stimulus vector.

// File: rtl/uart_bclk_pkg.sv
package uart_bclk_pkg;

    localparam int PRE_INT_W  = 6;
    localparam int PRE_FRAC_W = 3;
    localparam int DIV_W      = 16;
    localparam int OS_W       = 5;
    localparam int OS_MIN     = 4;
    localparam int OS_MAX     = 16;
    localparam int WR_W       = 16;
    localparam int ADDR_W     = 2;

    typedef enum logic [ADDR_W-1:0] {
        SEL_PRESCALE   = 2'd0,
        SEL_DIVISOR    = 2'd1,
        SEL_OVERSAMPLE = 2'd2,
        SEL_NONE       = 2'd3
    } cfg_sel_e;

    typedef struct packed {
        logic [PRE_INT_W-1:0]  pre_int;
        logic [PRE_FRAC_W-1:0] pre_frac;
        logic [DIV_W-1:0]      divisor;
        logic [OS_W-1:0]       os;
    } bclk_cfg_t;

    function automatic logic [OS_W-1:0] clamp_os(input logic [OS_W-1:0] raw);
        if (raw < OS_W'(OS_MIN)) return OS_W'(OS_MIN);
        if (raw > OS_W'(OS_MAX)) return OS_W'(OS_MAX);
        return raw;
    endfunction

    function automatic logic [PRE_INT_W-1:0] fix_int(input logic [PRE_INT_W-1:0] raw);
        return (raw == '0) ? PRE_INT_W'(1) : raw;
    endfunction

endpackage

// File: rtl/uart_bclk_prescaler.sv
module uart_bclk_prescaler #(
    parameter int INT_W  = 6,
    parameter int FRAC_W = 3
) (
    input  logic              clk,
    input  logic              rst,
    input  logic              restart,
    input  logic [INT_W-1:0]  div_int,
    input  logic [FRAC_W-1:0] div_frac,
    output logic              tick
);

    localparam int PER_W = INT_W + 1;

    typedef struct packed {
        logic [INT_W-1:0]  cnt;
        logic [FRAC_W-1:0] acc;
    } pre_st_t;

    pre_st_t st_d, st_q;

    logic [FRAC_W:0]  acc_sum;
    logic [PER_W-1:0] period;
    logic             last;

    always_comb begin
        acc_sum = {1'b0, st_q.acc} + {1'b0, div_frac};
        period  = {1'b0, div_int} + PER_W'(acc_sum[FRAC_W]);
        last    = ({1'b0, st_q.cnt} == (period - PER_W'(1)));
        tick    = last;
        st_d    = st_q;
        if (last) begin
            st_d.cnt = '0;
            st_d.acc = acc_sum[FRAC_W-1:0];
        end else begin
            st_d.cnt = st_q.cnt + INT_W'(1);
        end
        if (restart) begin
            st_d.acc = '0;
        end
    end

    always_ff @(posedge clk) begin
        if (rst) st_q <= '0;
        else     st_q <= st_d;
    end

    // R3: the cycle counter never runs past the longest legal period
    p_cnt_bound_r3: assert property (@(posedge clk) disable iff (rst)
        st_q.cnt <= div_int)
        else $error("prescaler counter out of range");

endmodule

// File: rtl/uart_bclk_counter.sv
module uart_bclk_counter #(
    parameter int W = 16
) (
    input  logic         clk,
    input  logic         rst,
    input  logic         in_tick,
    input  logic [W-1:0] limit,
    output logic         out_tick
);

    typedef struct packed {
        logic [W-1:0] cnt;
    } cnt_st_t;

    cnt_st_t      st_d, st_q;
    logic [W-1:0] last_val;

    always_comb begin
        last_val = limit - W'(1);
        out_tick = in_tick && (st_q.cnt == last_val);
        st_d     = st_q;
        if (in_tick) begin
            st_d.cnt = out_tick ? '0 : st_q.cnt + W'(1);
        end
    end

    always_ff @(posedge clk) begin
        if (rst) st_q <= '0;
        else     st_q <= st_d;
    end

    // R4 (divisor instance) and R5 (oversample instance): count stays below limit
    p_cnt_limit_r4: assert property (@(posedge clk) disable iff (rst)
        (limit != '0) |-> (st_q.cnt < limit))
        else $error("counter beyond limit");

endmodule

// File: rtl/uart_bitclk_gen.sv
module uart_bitclk_gen
    import uart_bclk_pkg::*;
#(
    parameter logic [PRE_INT_W-1:0]  RST_PRE_INT  = 6'd33,
    parameter logic [PRE_FRAC_W-1:0] RST_PRE_FRAC = 3'd7,
    parameter logic [DIV_W-1:0]      RST_DIV      = 16'd1,
    parameter logic [OS_W-1:0]       RST_OS       = 5'd16
) (
    input  logic              clk,
    input  logic              rst,
    input  logic              wr_en,
    input  logic [ADDR_W-1:0] wr_addr,
    input  logic [WR_W-1:0]   wr_data,
    output logic              sample_tick,
    output logic              bit_tick
);

    localparam bclk_cfg_t RST_CFG = '{
        pre_int:  RST_PRE_INT,
        pre_frac: RST_PRE_FRAC,
        divisor:  RST_DIV,
        os:       RST_OS
    };

    typedef struct packed {
        bclk_cfg_t shadow;
        bclk_cfg_t active;
        logic      pend;
    } gen_st_t;

    gen_st_t st_d, st_q;

    logic pre_tick;
    logic div_tick;
    logic bit_raw;
    logic load;
    logic wr_hit;

    assign load = bit_raw & st_q.pend;

    always_comb begin
        st_d   = st_q;
        wr_hit = 1'b0;
        if (load) begin
            st_d.active = st_q.shadow;
            st_d.pend   = 1'b0;
        end
        if (wr_en) begin
            case (cfg_sel_e'(wr_addr))
                SEL_PRESCALE: begin
                    st_d.shadow.pre_int  = fix_int(wr_data[PRE_FRAC_W +: PRE_INT_W]);
                    st_d.shadow.pre_frac = wr_data[PRE_FRAC_W-1:0];
                    wr_hit = 1'b1;
                end
                SEL_DIVISOR: begin
                    st_d.shadow.divisor = wr_data[DIV_W-1:0];
                    wr_hit = 1'b1;
                end
                SEL_OVERSAMPLE: begin
                    st_d.shadow.os = clamp_os(wr_data[OS_W-1:0]);
                    wr_hit = 1'b1;
                end
                default: wr_hit = 1'b0;
            endcase
        end
        if (wr_hit) begin
            st_d.pend = 1'b1;
        end
    end

    always_ff @(posedge clk) begin
        if (rst) begin
            st_q.shadow <= RST_CFG;
            st_q.active <= RST_CFG;
            st_q.pend   <= 1'b0;
        end else begin
            st_q <= st_d;
        end
    end

    uart_bclk_prescaler #(
        .INT_W  (PRE_INT_W),
        .FRAC_W (PRE_FRAC_W)
    ) u_prescale (
        .clk      (clk),
        .rst      (rst),
        .restart  (load),
        .div_int  (st_q.active.pre_int),
        .div_frac (st_q.active.pre_frac),
        .tick     (pre_tick)
    );

    uart_bclk_counter #(
        .W (DIV_W)
    ) u_divisor (
        .clk      (clk),
        .rst      (rst),
        .in_tick  (pre_tick),
        .limit    (st_q.active.divisor),
        .out_tick (div_tick)
    );

    uart_bclk_counter #(
        .W (OS_W)
    ) u_oversample (
        .clk      (clk),
        .rst      (rst),
        .in_tick  (div_tick),
        .limit    (st_q.active.os),
        .out_tick (bit_raw)
    );

    assign sample_tick = div_tick & ~rst;
    assign bit_tick    = bit_raw & ~rst;

    // R1: a bit strobe is always the final sample strobe of its bit
    p_bit_on_sample_r1: assert property (@(posedge clk) disable iff (rst)
        bit_tick |-> sample_tick)
        else $error("bit strobe without sample strobe");

    // R7: the running configuration changes only across a bit boundary
    p_cfg_hold_r7: assert property (@(posedge clk) disable iff (rst)
        !bit_tick |=> $stable(st_q.active))
        else $error("configuration changed mid-bit");

    // R5: the running oversample ratio stays within its legal range
    p_os_range_r5: assert property (@(posedge clk) disable iff (rst)
        (st_q.active.os >= OS_W'(OS_MIN)) && (st_q.active.os <= OS_W'(OS_MAX)))
        else $error("oversample ratio out of range");

endmodule

// File: tb/uart_bitclk_gen_tb.sv
module uart_bitclk_gen_tb;

    localparam int WD_LIMIT = 180000;

    typedef struct packed {
        logic [8:0]  pre;
        logic [15:0] dv;
        logic [4:0]  os;
        logic [7:0]  nbits;
        logic [15:0] exp_cyc;
        logic [15:0] exp_smp;
    } vec_t;

    // prescaler code = int<<3 | eighths; expected cycles/samples worked from R3-style sums
    localparam vec_t VECS [7] = '{
        '{pre: 9'd8,  dv: 16'd1, os: 5'd4,  nbits: 8'd8,  exp_cyc: 16'd32,   exp_smp: 16'd32},
        '{pre: 9'd31, dv: 16'd5, os: 5'd7,  nbits: 8'd64, exp_cyc: 16'd8680, exp_smp: 16'd448},
        '{pre: 9'd20, dv: 16'd3, os: 5'd16, nbits: 8'd4,  exp_cyc: 16'd480,  exp_smp: 16'd64},
        '{pre: 9'd9,  dv: 16'd1, os: 5'd5,  nbits: 8'd8,  exp_cyc: 16'd45,   exp_smp: 16'd40},
        '{pre: 9'd8,  dv: 16'd2, os: 5'd2,  nbits: 8'd4,  exp_cyc: 16'd32,   exp_smp: 16'd16},
        '{pre: 9'd8,  dv: 16'd1, os: 5'd20, nbits: 8'd4,  exp_cyc: 16'd64,   exp_smp: 16'd64},
        '{pre: 9'd0,  dv: 16'd1, os: 5'd4,  nbits: 8'd4,  exp_cyc: 16'd16,   exp_smp: 16'd16}
    };

    logic        clk = 1'b0;
    logic        rst = 1'b1;
    logic        wr_en = 1'b0;
    logic [1:0]  wr_addr = 2'd0;
    logic [15:0] wr_data = 16'd0;
    logic        sample_tick;
    logic        bit_tick;

    int checks = 0;
    int errors = 0;
    int total_cyc = 0;

    always #5 clk = ~clk;

    uart_bitclk_gen u_dut (
        .clk         (clk),
        .rst         (rst),
        .wr_en       (wr_en),
        .wr_addr     (wr_addr),
        .wr_data     (wr_data),
        .sample_tick (sample_tick),
        .bit_tick    (bit_tick)
    );

    task automatic summary();
        $display("Result: errors=%0d of %0d checks", errors, checks);
    endtask

    always @(posedge clk) begin
        total_cyc++;
        if (total_cyc == WD_LIMIT) begin
            checks++;
            errors++;
            $display("FAIL watchdog (all R) actual=%0d expected<%0d", total_cyc, WD_LIMIT);
            summary();
            $finish;
        end
    end

    task automatic check(input bit ok, input string tag, input longint act, input longint exp);
        checks++;
        if (!ok) begin
            errors++;
            $display("FAIL %s actual=%0d expected=%0d", tag, act, exp);
        end
    endtask

    task automatic wr(input logic [1:0] a, input logic [15:0] d);
        @(negedge clk);
        wr_en = 1'b1; wr_addr = a; wr_data = d;
        @(negedge clk);
        wr_en = 1'b0;
    endtask

    task automatic wait_tick();
        while (!bit_tick) @(negedge clk);
    endtask

    task automatic measure(input int nbits, output int cyc, output int smp);
        int b = 0;
        cyc = 0; smp = 0;
        while (b < nbits) begin
            @(negedge clk);
            wr_en = 1'b0;
            cyc++;
            if (sample_tick) smp++;
            if (bit_tick) b++;
        end
    endtask

    task automatic reset_and_check(input string tag);
        int cyc = 1;
        int first_smp = 0;
        int smp = 0;
        bit quiet = 1'b1;
        rst = 1'b1;
        for (int i = 0; i < 4; i++) begin
            @(negedge clk);
            if (sample_tick || bit_tick) quiet = 1'b0;
        end
        check(quiet, {tag, " R2 strobes low in reset"}, quiet, 1);
        rst = 1'b0;
        while (1) begin
            @(negedge clk);
            cyc++;
            if (sample_tick) begin
                smp++;
                if (first_smp == 0) first_smp = cyc;
            end
            if (bit_tick) break;
        end
        check(first_smp == 33, {tag, " R2 first sample cycle"}, first_smp, 33);
        check(cyc == 542, {tag, " R2 first bit cycle"}, cyc, 542);
        check(smp == 16, {tag, " R1 samples per legacy bit"}, smp, 16);
    endtask

    initial begin
        int cyc, smp;
        real rate, err;

        // R2: reset state and legacy default timing
        reset_and_check("boot");
        rate = 62.5e6 / 542.0;
        check((rate > 115313.0) && (rate < 115315.0), "R2 legacy base rate", longint'(rate), 115314);

        // R3 R4 R5 R6: vector walk
        foreach (VECS[i]) begin
            wr(2'd0, {7'd0, VECS[i].pre});
            wr(2'd1, VECS[i].dv);
            wr(2'd2, {11'd0, VECS[i].os});
            wait_tick();
            measure(int'(VECS[i].nbits), cyc, smp);
            check(cyc == int'(VECS[i].exp_cyc), $sformatf("R3/R6 vec%0d bit cycles", i),
                  cyc, VECS[i].exp_cyc);
            check(smp == int'(VECS[i].exp_smp), $sformatf("R1/R5 vec%0d samples", i),
                  smp, VECS[i].exp_smp);
            if (i == 1) begin
                rate = 62.5e6 * 64.0 / real'(cyc);
                err  = (rate - 460800.0) / 460800.0;
                if (err < 0.0) err = -err;
                check(err < 0.000065, "R6 460800 accuracy", longint'(rate), 460800);
            end
        end

        // R9: address 3 write leaves timing at 4 cycles per bit
        wr(2'd3, 16'd5);
        wait_tick();
        measure(2, cyc, smp);
        check(cyc == 8, "R9 addr3 ignored cycles", cyc, 8);
        check(smp == 8, "R9 addr3 ignored samples", smp, 8);

        // R7 R8: write in the same cycle as a loading bit boundary
        wait_tick();
        wr_en = 1'b1; wr_addr = 2'd2; wr_data = 16'd8;
        measure(1, cyc, smp);
        check(cyc == 4, "R7 old timing until boundary", cyc, 4);
        wr_en = 1'b1; wr_addr = 2'd1; wr_data = 16'd2;
        measure(1, cyc, smp);
        check(cyc == 8, "R8 boundary loads earlier write", cyc, 8);
        measure(1, cyc, smp);
        check(cyc == 16, "R8 colliding write at next boundary", cyc, 16);

        // R4: divisor 0 divides by 65536
        wr(2'd1, 16'd0);
        wr(2'd2, 16'd4);
        wait_tick();
        cyc = 0;
        while (1) begin
            @(negedge clk);
            cyc++;
            if (sample_tick) break;
        end
        check(cyc == 65536, "R4 divisor zero", cyc, 65536);

        // R2: reset mid-period clears counters
        reset_and_check("mid");

        summary();
        $finish;
    end

endmodule